// File: doc/BRIEF.md
# Dual-Plane Ingress Packet Segmenter

This block takes fixed-length packets from a 32-bit ingress word bus, holds them in a two-slot packet store, and plays each one out on two redundant switch-plane outputs (X and Y) at the same time. Every packet is split into four equal logical units. A unit can end partway through a bus word, so each output word carries the index of the unit that holds its first byte.

The egress side runs a slot clock that never stops. One slot lasts as many cycles as the packet has bus words, and slots follow each other with no gap. When a slot begins and a complete packet is waiting, that packet fills the slot. Otherwise the slot carries an idle packet of all-zero words, sized by the current length setting.

The packet length in bytes is set through a write strobe. A new setting is held pending until the ingress side is between packets. Each plane has an enable, and the enable is captured once at the start of every slot. A plane that is disabled for a slot stays silent for that whole slot, and the other plane is not affected.

Top module: `dual_plane_segmenter`

## Requirements
- R1: The legal lengths are 64, 68, 72, 76 and 80 bytes. A `cfg_wr` strobe whose `cfg_len` is outside 64..80 or not a multiple of 4 is ignored, and the previous length stays in force. After reset the length is 64.
- R2: A packet uses the length in force in the cycle its first word is accepted. A length write made while a packet is partly received applies only from the next packet.
- R3: A packet of L bytes is accepted as L/4 ingress words and sent as L/4 egress words, with the words in their arrival order.
- R4: Output word w of a slot of L bytes carries `unit` = the number of k in {1,2,3} with 16*w >= k*L. This is the unit holding the word's first byte, so word 0 has unit 0 and the unit value never drops within a slot.
- R5: When both planes are enabled, X and Y carry identical valid, sop, idle, unit and data in every cycle.
- R6: Slots follow each other back to back. `sop` is high on the first word only, and the next `sop` comes exactly L/4 cycles later, where L is the length of the slot that just ended.
- R7: If no complete packet is stored when a slot starts, the slot is idle: `idle` is high, the data is zero, and the slot is sized by the current length setting.
- R8: Each plane enable is sampled only at slot start. A plane that is disabled for a slot keeps valid, sop, idle, unit and data at 0 for that whole slot. A change to an enable partway through a slot has no effect until the next slot.
- R9: Stored packets leave in the order they were accepted, and each leaves exactly once.
- R10: While reset is held and in the first cycle after it, both planes are silent (valid low) and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Length write strobe |
| cfg_len | input | 8 | Requested packet length in bytes |
| in_valid | input | 1 | Ingress word valid |
| in_data | input | 32 | Ingress word |
| in_ready | output | 1 | Store can accept a word |
| plane_en_x | input | 1 | Plane X enable, sampled at slot start |
| plane_en_y | input | 1 | Plane Y enable, sampled at slot start |
| x_valid | output | 1 | Plane X word valid |
| x_sop | output | 1 | Plane X first word of slot |
| x_idle | output | 1 | Plane X slot is an idle packet |
| x_unit | output | 2 | Plane X logical unit index |
| x_data | output | 32 | Plane X word |
| y_valid | output | 1 | Plane Y word valid |
| y_sop | output | 1 | Plane Y first word of slot |
| y_idle | output | 1 | Plane Y slot is an idle packet |
| y_unit | output | 2 | Plane Y logical unit index |
| y_data | output | 32 | Plane Y word |

## Verification
The assertions assume that reset is held through at least one rising edge before any traffic starts, and that `in_valid`, `cfg_wr` and the plane enables are never unknown once reset is released. The bench drives every input to a defined level from time zero, changes them only on falling edges, and holds the enables fixed except in the one test that switches an enable off partway through a slot. It writes a new length only when no packet is partly received, apart from the single test that is meant to write mid-packet. This keeps the pending-length path and the capture of the ingress length inside the conditions that the length-hold and slot-framing assertions rely on.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef struct packed {
    logic       valid;
    logic       sop;
    logic       idle;
    logic [1:0] unit;
  } lane_t;

  function automatic logic len_legal(input logic [7:0] len, input int lo, input int hi);
    return (int'(len) >= lo) && (int'(len) <= hi) && (len[1:0] == 2'b00);
  endfunction

  // unit holding the first byte of a word: count thresholds crossed
  function automatic logic [1:0] unit_of(input logic [7:0] widx, input logic [7:0] len);
    logic [11:0] pos;
    logic [11:0] l1;
    pos = {widx, 4'b0000};
    l1  = {4'b0000, len};
    return 2'(pos >= l1) + 2'(pos >= (l1 << 1)) + 2'(pos >= (l1 * 12'd3));
  endfunction

endpackage

// File: rtl/seg_len_cfg.sv
module seg_len_cfg
  import seg_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 80,
  parameter int DEF_LEN = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_len,
  input  logic       at_boundary,
  output logic [7:0] len_q
);

  logic [7:0] pend_len;
  logic       pend_v;
  logic       wr_ok;

  assign wr_ok = cfg_wr && len_legal(cfg_len, MIN_LEN, MAX_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= 8'(DEF_LEN);
      pend_len <= 8'(DEF_LEN);
      pend_v   <= 1'b0;
    end else begin
      if (at_boundary && pend_v) begin
        len_q  <= pend_len;
        pend_v <= 1'b0;
      end
      if (wr_ok) begin
        pend_len <= cfg_len;
        pend_v   <= 1'b1;
      end
    end
  end

  // R1: the active length is always one of the legal settings
  p_len_legal_r1: assert property (@(posedge clk) disable iff (rst)
    len_legal(len_q, MIN_LEN, MAX_LEN));

endmodule

// File: rtl/seg_pkt_store.sv
module seg_pkt_store
  import seg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [7:0]        cur_len,
  output logic              at_boundary,
  output logic              pkt_ready,
  output logic [7:0]        pkt_len,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_zero,
  input  logic              rd_release,
  output logic [DATA_W-1:0] rd_data
);

  localparam int ADDR_W = IDX_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [1:0]        full;
  logic [7:0]        tag_len [2];
  logic              wr_ptr;
  logic              rd_ptr;
  logic [IDX_W-1:0]  in_cnt;
  logic [7:0]        in_len;
  logic [7:0]        len_now;
  logic [7:0]        words_now;
  logic              accept;
  logic              last_word;

  assign in_ready    = !full[wr_ptr];
  assign accept      = in_valid && in_ready;
  assign len_now     = (in_cnt == '0) ? cur_len : in_len;
  assign words_now   = len_now >> 2;
  assign last_word   = accept && (8'(in_cnt) == words_now - 8'd1);
  assign at_boundary = (in_cnt == '0) && !accept;
  assign pkt_ready   = full[rd_ptr];
  assign pkt_len     = tag_len[rd_ptr];

  // storage array: write port
  always_ff @(posedge clk) begin
    if (accept) mem[{wr_ptr, in_cnt}] <= in_data;
  end

  // storage array: registered read port with synchronous clear
  always_ff @(posedge clk) begin
    if (rst || rd_zero) rd_data <= '0;
    else                rd_data <= mem[{rd_ptr, rd_idx}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full       <= 2'b00;
      wr_ptr     <= 1'b0;
      rd_ptr     <= 1'b0;
      in_cnt     <= '0;
      in_len     <= 8'd0;
      tag_len[0] <= 8'd0;
      tag_len[1] <= 8'd0;
    end else begin
      if (accept) begin
        if (in_cnt == '0) in_len <= cur_len;
        if (last_word) begin
          full[wr_ptr]    <= 1'b1;
          tag_len[wr_ptr] <= len_now;
          wr_ptr          <= ~wr_ptr;
          in_cnt          <= '0;
        end else begin
          in_cnt <= in_cnt + IDX_W'(1);
        end
      end
      if (rd_release) begin
        full[rd_ptr] <= 1'b0;
        rd_ptr       <= ~rd_ptr;
      end
    end
  end

  // R2: once a packet has started, its captured length does not move
  p_len_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (in_cnt != '0) && !last_word |=> $stable(in_len));

  // R9: a slot only releases a buffer that was holding a packet
  p_release_full_r9: assert property (@(posedge clk) disable iff (rst)
    rd_release |-> full[rd_ptr]);

endmodule

// File: rtl/seg_slot_sched.sv
module seg_slot_sched
  import seg_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_ready,
  input  logic [7:0]       pkt_len,
  input  logic [7:0]       idle_len,
  input  logic [1:0]       plane_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_zero,
  output logic             rd_release,
  output lane_t [1:0]      lanes
);

  logic [IDX_W-1:0] e_cnt;
  logic [7:0]       e_len;
  logic             e_idle;
  logic [1:0]       e_en;

  logic             start;
  logic             take;
  logic [7:0]       slot_len;
  logic [7:0]       slot_nw;
  logic             cur_idle;
  logic [1:0]       cur_en;
  logic             last;
  logic [1:0]       cur_unit;

  assign start    = (e_cnt == '0);
  assign take     = start && pkt_ready;
  assign slot_len = start ? (take ? pkt_len : idle_len) : e_len;
  assign slot_nw  = slot_len >> 2;
  assign cur_idle = start ? !take : e_idle;
  assign cur_en   = start ? plane_en : e_en;
  assign last     = (8'(e_cnt) == slot_nw - 8'd1);
  assign cur_unit = unit_of(8'(e_cnt), slot_len);

  assign rd_idx     = e_cnt;
  assign rd_zero    = cur_idle;
  assign rd_release = last && !cur_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_cnt  <= '0;
      e_len  <= 8'd0;
      e_idle <= 1'b1;
      e_en   <= 2'b00;
    end else begin
      e_cnt <= last ? '0 : e_cnt + IDX_W'(1);
      if (start) begin
        e_len  <= slot_len;
        e_idle <= cur_idle;
        e_en   <= cur_en;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lanes <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        lanes[p].valid <= cur_en[p];
        lanes[p].sop   <= cur_en[p] && start;
        lanes[p].idle  <= cur_en[p] && cur_idle;
        lanes[p].unit  <= cur_en[p] ? cur_unit : 2'd0;
      end
    end
  end

  // R6: slots are at least two words long, so sop never repeats back to back
  p_sop_single_r6: assert property (@(posedge clk) disable iff (rst)
    lanes[0].sop |=> !lanes[0].sop);

  // R8: the lane enable can only change at a slot start
  p_en_latched_r8: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(e_en));

endmodule

// File: rtl/dual_plane_segmenter.sv
module dual_plane_segmenter
  import seg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 80,
  parameter int DEF_LEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_len,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              plane_en_x,
  input  logic              plane_en_y,
  output logic              x_valid,
  output logic              x_sop,
  output logic              x_idle,
  output logic [1:0]        x_unit,
  output logic [DATA_W-1:0] x_data,
  output logic              y_valid,
  output logic              y_sop,
  output logic              y_idle,
  output logic [1:0]        y_unit,
  output logic [DATA_W-1:0] y_data
);

  localparam int MAX_WORDS = MAX_LEN / 4;
  localparam int IDX_W     = $clog2(MAX_WORDS);

  logic [7:0]        len_q;
  logic              at_boundary;
  logic              pkt_ready;
  logic [7:0]        pkt_len;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_zero;
  logic              rd_release;
  logic [DATA_W-1:0] rd_data;
  lane_t [1:0]       lanes;
  logic [DATA_W-1:0] lane_data [2];

  seg_len_cfg #(
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .DEF_LEN(DEF_LEN)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_len(cfg_len),
    .at_boundary(at_boundary), .len_q(len_q)
  );

  seg_pkt_store #(
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cur_len(len_q), .at_boundary(at_boundary),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len), .rd_idx(rd_idx),
    .rd_zero(rd_zero), .rd_release(rd_release), .rd_data(rd_data)
  );

  seg_slot_sched #(
    .IDX_W(IDX_W)
  ) u_sched (
    .clk(clk), .rst(rst), .pkt_ready(pkt_ready), .pkt_len(pkt_len),
    .idle_len(len_q), .plane_en({plane_en_y, plane_en_x}),
    .rd_idx(rd_idx), .rd_zero(rd_zero), .rd_release(rd_release),
    .lanes(lanes)
  );

  for (genvar p = 0; p < 2; p++) begin : g_plane
    assign lane_data[p] = lanes[p].valid ? rd_data : '0;

    // R4: a slot always opens in unit 0
    p_sop_unit_zero_r4: assert property (@(posedge clk) disable iff (rst)
      lanes[p].sop |-> (lanes[p].unit == 2'd0));

    // R4: within a slot the unit index holds or steps up by one
    p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
      lanes[p].valid && !lanes[p].sop && $past(lanes[p].valid) |->
        (lanes[p].unit == $past(lanes[p].unit)) ||
        (lanes[p].unit == $past(lanes[p].unit) + 2'd1));

    // R7: idle slots carry zero data
    p_idle_blank_r7: assert property (@(posedge clk) disable iff (rst)
      lanes[p].valid && lanes[p].idle |-> (lane_data[p] == '0));
  end

  // R5: the two planes carry the same framing and data when both are live
  p_dup_lanes_r5: assert property (@(posedge clk) disable iff (rst)
    lanes[0].valid && lanes[1].valid |->
      (lanes[0] == lanes[1]) && (lane_data[0] == lane_data[1]));

  assign x_valid = lanes[0].valid;
  assign x_sop   = lanes[0].sop;
  assign x_idle  = lanes[0].idle;
  assign x_unit  = lanes[0].unit;
  assign x_data  = lane_data[0];
  assign y_valid = lanes[1].valid;
  assign y_sop   = lanes[1].sop;
  assign y_idle  = lanes[1].idle;
  assign y_unit  = lanes[1].unit;
  assign y_data  = lane_data[1];

endmodule

// File: tb/dual_plane_segmenter_bench.sv
module dual_plane_segmenter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_len = 8'd0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic        in_ready;
  logic        plane_en_x = 1'b1;
  logic        plane_en_y = 1'b1;
  logic        x_valid, x_sop, x_idle, y_valid, y_sop, y_idle;
  logic [1:0]  x_unit, y_unit;
  logic [31:0] x_data, y_data;

  int n_vec = 0;
  int n_bad = 0;
  int model_len = 64;

  always #4 clk = ~clk;

  dual_plane_segmenter u_dual_plane_segmenter (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_len(cfg_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .plane_en_x(plane_en_x), .plane_en_y(plane_en_y),
    .x_valid(x_valid), .x_sop(x_sop), .x_idle(x_idle), .x_unit(x_unit), .x_data(x_data),
    .y_valid(y_valid), .y_sop(y_sop), .y_idle(y_idle), .y_unit(y_unit), .y_data(y_data)
  );

  // {length, en_x, en_y, seed}
  localparam logic [25:0] VEC [8] = '{
    {8'd72, 1'b1, 1'b1, 16'h1000},
    {8'd80, 1'b1, 1'b1, 16'h2000},
    {8'd70, 1'b1, 1'b1, 16'h3000},
    {8'd64, 1'b1, 1'b0, 16'h4000},
    {8'd76, 1'b0, 1'b1, 16'h5000},
    {8'd84, 1'b1, 1'b1, 16'h6000},
    {8'd68, 1'b1, 1'b1, 16'h7000},
    {8'd0,  1'b1, 1'b1, 16'h8000}
  };

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bit legal(input int l);
    return (l >= 64) && (l <= 80) && ((l % 4) == 0);
  endfunction

  function automatic logic [31:0] word_of(input int seed, input int j);
    return {16'(seed), 16'(j)};
  endfunction

  task automatic write_len(input int l);
    @(negedge clk);
    cfg_wr  = 1'b1;
    cfg_len = 8'(l);
    @(negedge clk);
    cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    if (legal(l)) model_len = l;
  endtask

  task automatic send(input int nw, input int seed, input int mid_at, input int mid_len);
    int i = 0;
    while (i < nw) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = word_of(seed, i);
      cfg_wr   = (i == mid_at);
      cfg_len  = 8'(mid_len);
      if (in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    cfg_wr   = 1'b0;
  endtask

  task automatic capture(input int len, input int seed, input bit ex, input bit ey,
                         input int drop_y_at, input string req);
    int  t = 0;
    bit  found = 0;
    int  nw = len / 4;
    logic [36:0] gx, gy, ev;
    while (!found && t < 400) begin
      if ((x_valid && x_sop && !x_idle) || (y_valid && y_sop && !y_idle)) found = 1;
      else begin
        @(negedge clk);
        t++;
      end
    end
    chk(found, {req, " data slot seen"}, longint'(found), 1);
    if (!found) return;
    for (int j = 0; j < nw; j++) begin
      if (j > 0) @(negedge clk);
      ev = {1'b1, (j == 0), 1'b0, 2'((j * 16) / len), word_of(seed, j)};
      gx = {x_valid, x_sop, x_idle, x_unit, x_data};
      gy = {y_valid, y_sop, y_idle, y_unit, y_data};
      chk(gx == (ex ? ev : 37'd0), {req, " R3 R4 R5 R8 plane X word"}, longint'(gx), longint'(ex ? ev : 37'd0));
      chk(gy == (ey ? ev : 37'd0), {req, " R3 R4 R5 R8 plane Y word"}, longint'(gy), longint'(ey ? ev : 37'd0));
      if (j == drop_y_at) plane_en_y = 1'b0;
    end
    @(negedge clk);
    chk(plane_en_x ? x_sop : !x_valid, {req, " R6 next slot on X"}, longint'({x_valid, x_sop}), 1);
    chk(plane_en_y ? y_sop : !y_valid, {req, " R6 R8 next slot on Y"}, longint'({y_valid, y_sop}), 1);
  endtask

  task automatic idle_gap(input string req, output int gap);
    int t = 0;
    gap = 0;
    while (!(x_valid && x_sop) && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(x_idle && (x_data == 0), {req, " R7 idle slot blank"}, longint'({x_idle, x_data}), 64'h1_0000_0000);
    do begin
      @(negedge clk);
      gap++;
    end while (!x_sop && gap < 200);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int gap;
    // R10: reset state
    repeat (4) @(negedge clk);
    chk(!x_valid && !y_valid, "R10 planes silent in reset", longint'({x_valid, y_valid}), 0);
    chk(in_ready, "R10 in_ready in reset", longint'(in_ready), 1);
    rst = 1'b0;
    chk(!x_valid && !y_valid, "R10 planes silent after release", longint'({x_valid, y_valid}), 0);
    @(negedge clk);
    // R7 R5: first slot is idle on both planes at the default length
    chk({x_valid, x_sop, x_idle, x_data} == {3'b111, 32'd0}, "R7 first idle slot X",
        longint'({x_valid, x_sop, x_idle, x_data}), 64'h7_0000_0000);
    chk({y_valid, y_sop, y_idle, y_data} == {3'b111, 32'd0}, "R5 first idle slot Y",
        longint'({y_valid, y_sop, y_idle, y_data}), 64'h7_0000_0000);
    idle_gap("R1 default", gap);
    chk(gap == 16, "R1 R6 default idle slot length", gap, 16);

    // R1 R7: idle slots follow a new legal length
    write_len(80);
    repeat (40) @(negedge clk);
    idle_gap("R1 80", gap);
    chk(gap == 20, "R1 R6 idle slot length 80", gap, 20);

    // table of length / plane / seed vectors
    for (int v = 0; v < 8; v++) begin
      int vl = int'(VEC[v][25:18]);
      write_len(vl);
      chk(legal(vl) ? (model_len == vl) : 1'b1, "R1 model", model_len, vl);
      plane_en_x = VEC[v][17];
      plane_en_y = VEC[v][16];
      send(model_len / 4, int'(VEC[v][15:0]), -1, 0);
      capture(model_len, int'(VEC[v][15:0]), VEC[v][17], VEC[v][16], -1,
              legal(vl) ? "R1 R3 legal length" : "R1 illegal length kept");
    end
    plane_en_x = 1'b1;
    plane_en_y = 1'b1;

    // R2: length written mid-packet applies only from the next packet
    write_len(80);
    send(20, 16'h0A00, 5, 64);
    capture(80, 16'h0A00, 1'b1, 1'b1, -1, "R2 old length kept");
    model_len = 64;
    send(16, 16'h0B00, -1, 0);
    capture(64, 16'h0B00, 1'b1, 1'b1, -1, "R2 new length used");

    // R9: two packets back to back leave in order, once each
    fork
      begin
        send(16, 16'h0C00, -1, 0);
        send(16, 16'h0D00, -1, 0);
      end
      begin
        capture(64, 16'h0C00, 1'b1, 1'b1, -1, "R9 first packet");
        capture(64, 16'h0D00, 1'b1, 1'b1, -1, "R9 second packet");
      end
    join
    repeat (40) @(negedge clk);
    chk(!(x_valid && !x_idle), "R9 no repeat of sent packets", longint'(x_idle), 1);

    // R8: dropping an enable mid-slot finishes the slot, then the plane goes quiet
    send(16, 16'h0E00, -1, 0);
    capture(64, 16'h0E00, 1'b1, 1'b1, 3, "R8 mid-slot disable");
    repeat (20) @(negedge clk);
    chk(!y_valid && x_valid, "R8 disabled plane silent, other runs", longint'({x_valid, y_valid}), 2);
    plane_en_y = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule